// File: doc/BRIEF.md
# Compare-and-Swap Instruction Decoder

This block looks at one 32-bit instruction word and tells the pipeline whether the word is an atomic compare-and-swap. If it is, the block also reports the operand size, the three register indices and the ordering bits. The three sizes are word, doubleword and quadword. The register indices are the address base, the compare value that is also the destination, and the swap value. The ordering bits are acquire and release. The logic is purely combinational, so the result is ready in the same cycle the word is presented.

A parameter sets the base register width to 32 or 64. Some legality rules depend on that width. When an operand is twice the register width, the compare and swap values each occupy an even/odd register pair. In that case an odd first index is a reserved encoding. On a 32-bit base the quadword size does not exist at all. The block does not refuse such words. It recognises them as belonging to the family and raises an illegal-encoding flag, so that the trap logic downstream can act on them. Other atomic operations, register access and memory traffic are handled elsewhere.

Top module: `casDecoder`

## Requirements
- R1: Bits [6:0] of the word are the major opcode. Bits [11:7], [19:15] and [24:20] give the compare/destination index, the address index and the swap index. These three indices appear on `cmpDstReg`, `addrReg` and `swapSrcReg` for every word.
- R2: `casHit` is high only when bits [6:0] equal 7'b0101111 and bits [31:27] equal 5'b00101. Any other opcode or selector value holds `casHit` and `illegal` low.
- R3: The size field is bits [14:12]. The value 3'b010 gives word, 3'b011 gives doubleword and 3'b100 gives quadword. `opSize` reports these as 0, 1 and 2. Any other size-field value holds `casHit` low, and `opSize` reads 0 whenever `casHit` is low.
- R4: When the base width is 32, a quadword word raises `casHit` and `illegal` together, and `pairMode` stays low.
- R5: `pairMode` is high exactly when `casHit` is high and the operand is twice the base width. That means doubleword on a 32-bit base and quadword on a 64-bit base.
- R6: When `pairMode` is high, `illegal` is high if and only if bit 0 of the compare/destination index or bit 0 of the swap index is 1. The parity of the address index has no effect.
- R7: A word form on either base, or a doubleword form on a 64-bit base, never raises `illegal`, whatever the register parities are.
- R8: `acquireReq` follows bit 26 of the word and `releaseReq` follows bit 25.
- R9: `illegal` is never high while `casHit` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Instruction word to decode |
| casHit | output | 1 | Word belongs to the compare-and-swap family |
| illegal | output | 1 | Family member with a reserved or unsupported encoding |
| opSize | output | 2 | 0 word, 1 doubleword, 2 quadword |
| addrReg | output | 5 | Address base register index |
| cmpDstReg | output | 5 | Compare value / destination register index |
| swapSrcReg | output | 5 | Swap value source register index |
| pairMode | output | 1 | Compare and swap values occupy register pairs |
| acquireReq | output | 1 | Acquire ordering requested |
| releaseReq | output | 1 | Release ordering requested |

## Verification
The bench builds two copies of the decoder at once, one with a 32-bit base and one with a 64-bit base, and drives the same word into both. With both copies running, the quadword rejection and the move of pair mode from doubleword to quadword can be seen side by side. Every value of the size field is swept on both copies. Each sweep runs against all four parity combinations of the destination and swap indices and all four settings of the ordering bits. That covers every rule that depends on the base width and every reserved-register case.

// File: rtl/casDecPkg.sv
package casDecPkg;

  localparam int INSTR_W = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [6:0] ATOMIC_MAJOR = 7'b0101111;
  localparam logic [4:0] CAS_SELECT = 5'b00101;

  localparam logic [2:0] F3_WORD = 3'b010;
  localparam logic [2:0] F3_DOUBLE = 3'b011;
  localparam logic [2:0] F3_QUAD = 3'b100;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_DOUBLE = 2'd1,
    SZ_QUAD = 2'd2
  } opSize_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic familyMatch;
    logic sizeKnown;
    opSize_t size;
    logic pairForm;
    logic sizeBanned;
  } ctrlStrobe_t;

endpackage

// File: rtl/casFieldPath.sv
module casFieldPath
  import casDecPkg::*;
(
  input  logic [INSTR_W-1:0] instrWord,
  input  ctrlStrobe_t strobe,
  output logic [6:0] opcodeField,
  output logic [2:0] sizeField,
  output logic [4:0] selectField,
  output logic casHit,
  output logic illegal,
  output logic [1:0] opSize,
  output logic [REG_IDX_W-1:0] addrReg,
  output logic [REG_IDX_W-1:0] cmpDstReg,
  output logic [REG_IDX_W-1:0] swapSrcReg,
  output logic pairMode,
  output logic acquireReq,
  output logic releaseReq
);

  localparam int OPC_LSB = 0;
  localparam int RD_LSB = 7;
  localparam int F3_LSB = 12;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;
  localparam int RL_BIT = 25;
  localparam int AQ_BIT = 26;
  localparam int F5_LSB = 27;

  logic oddPairReg;
  logic hitInt;

  always_comb begin
    opcodeField = instrWord[OPC_LSB +: 7];
    sizeField = instrWord[F3_LSB +: 3];
    selectField = instrWord[F5_LSB +: 5];
    cmpDstReg = instrWord[RD_LSB +: REG_IDX_W];
    addrReg = instrWord[RS1_LSB +: REG_IDX_W];
    swapSrcReg = instrWord[RS2_LSB +: REG_IDX_W];
    acquireReq = instrWord[AQ_BIT];
    releaseReq = instrWord[RL_BIT];
  end

  always_comb begin
    hitInt = strobe.familyMatch & strobe.sizeKnown;
    oddPairReg = cmpDstReg[0] | swapSrcReg[0];
    casHit = hitInt;
    pairMode = hitInt & strobe.pairForm;
    illegal = hitInt & (strobe.sizeBanned | (strobe.pairForm & oddPairReg));
    opSize = hitInt ? strobe.size : SZ_WORD;
  end

endmodule

// File: rtl/casLegalCtrl.sv
module casLegalCtrl
  import casDecPkg::*;
#(
  parameter int BASE_WIDTH = 64
) (
  input  logic [6:0] opcodeField,
  input  logic [2:0] sizeField,
  input  logic [4:0] selectField,
  output ctrlStrobe_t strobe
);

  localparam int PAIR_OPERAND_W = 2 * BASE_WIDTH;
  localparam bit WIDE_BASE = (BASE_WIDTH >= 64);

  logic pairDouble;
  logic pairQuad;
  logic quadBanned;

  generate
    if (WIDE_BASE) begin : g_wide
      assign pairDouble = 1'b0;
      assign pairQuad = (PAIR_OPERAND_W == 128);
      assign quadBanned = 1'b0;
    end else begin : g_narrow
      assign pairDouble = (PAIR_OPERAND_W == 64);
      assign pairQuad = 1'b0;
      assign quadBanned = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe = '0;
    strobe.familyMatch = (opcodeField == ATOMIC_MAJOR) && (selectField == CAS_SELECT);
    unique case (sizeField)
      F3_WORD: begin
        strobe.sizeKnown = 1'b1;
        strobe.size = SZ_WORD;
      end
      F3_DOUBLE: begin
        strobe.sizeKnown = 1'b1;
        strobe.size = SZ_DOUBLE;
        strobe.pairForm = pairDouble;
      end
      F3_QUAD: begin
        strobe.sizeKnown = 1'b1;
        strobe.size = SZ_QUAD;
        strobe.pairForm = pairQuad;
        strobe.sizeBanned = quadBanned;
      end
      default: strobe.sizeKnown = 1'b0;
    endcase
  end

endmodule

// File: rtl/casDecoder.sv
module casDecoder
  import casDecPkg::*;
#(
  parameter int BASE_WIDTH = 64
) (
  input  logic [31:0] instrWord,
  output logic casHit,
  output logic illegal,
  output logic [1:0] opSize,
  output logic [4:0] addrReg,
  output logic [4:0] cmpDstReg,
  output logic [4:0] swapSrcReg,
  output logic pairMode,
  output logic acquireReq,
  output logic releaseReq
);

  ctrlStrobe_t strobe;
  logic [6:0] opcodeField;
  logic [2:0] sizeField;
  logic [4:0] selectField;

  casFieldPath u_path (
    .instrWord(instrWord),
    .strobe(strobe),
    .opcodeField(opcodeField),
    .sizeField(sizeField),
    .selectField(selectField),
    .casHit(casHit),
    .illegal(illegal),
    .opSize(opSize),
    .addrReg(addrReg),
    .cmpDstReg(cmpDstReg),
    .swapSrcReg(swapSrcReg),
    .pairMode(pairMode),
    .acquireReq(acquireReq),
    .releaseReq(releaseReq)
  );

  casLegalCtrl #(.BASE_WIDTH(BASE_WIDTH)) u_ctrl (
    .opcodeField(opcodeField),
    .sizeField(sizeField),
    .selectField(selectField),
    .strobe(strobe)
  );

endmodule

// File: rtl/casDecoderChecker.sv
module casDecoderChecker #(
  parameter int BASE_WIDTH = 64
) (
  input logic casHit,
  input logic illegal,
  input logic [1:0] opSize,
  input logic [4:0] cmpDstReg,
  input logic [4:0] swapSrcReg,
  input logic pairMode
);

  always_comb begin
    // R9
    a_r9_illegal_needs_hit: assert (!illegal || casHit);
    // R3
    a_r3_size_code_range: assert (!casHit || opSize != 2'd3);
    // R3
    a_r3_size_zero_when_miss: assert (casHit || opSize == 2'd0);
    // R5
    a_r5_pair_needs_hit: assert (!pairMode || casHit);
    // R6
    a_r6_odd_pair_flagged: assert (!(pairMode && (cmpDstReg[0] || swapSrcReg[0])) || illegal);
    // R6
    a_r6_even_pair_legal: assert (!(pairMode && !cmpDstReg[0] && !swapSrcReg[0]) || !illegal);
    // R4
    a_r4_narrow_quad_rejected: assert (!(BASE_WIDTH == 32 && casHit && opSize == 2'd2) || (illegal && !pairMode));
    // R7
    a_r7_single_reg_legal: assert (!(casHit && !pairMode && (opSize == 2'd0 || (BASE_WIDTH == 64 && opSize == 2'd1))) || !illegal);
  end

endmodule

bind casDecoder casDecoderChecker #(.BASE_WIDTH(BASE_WIDTH)) u_checker (
  .casHit(casHit),
  .illegal(illegal),
  .opSize(opSize),
  .cmpDstReg(cmpDstReg),
  .swapSrcReg(swapSrcReg),
  .pairMode(pairMode)
);

// File: tb/casDecoder_bench.sv
`timescale 1ns/1ps
module casDecoder_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [31:0] instrWord;

  logic hit64, ill64, pair64, aq64, rl64;
  logic [1:0] size64;
  logic [4:0] a64, d64, s64;
  logic hit32, ill32, pair32, aq32, rl32;
  logic [1:0] size32;
  logic [4:0] a32, d32, s32;

  casDecoder #(.BASE_WIDTH(64)) u_casDecoder (
    .instrWord(instrWord), .casHit(hit64), .illegal(ill64), .opSize(size64),
    .addrReg(a64), .cmpDstReg(d64), .swapSrcReg(s64), .pairMode(pair64),
    .acquireReq(aq64), .releaseReq(rl64)
  );

  casDecoder #(.BASE_WIDTH(32)) u_casDecoder32 (
    .instrWord(instrWord), .casHit(hit32), .illegal(ill32), .opSize(size32),
    .addrReg(a32), .cmpDstReg(d32), .swapSrcReg(s32), .pairMode(pair32),
    .acquireReq(aq32), .releaseReq(rl32)
  );

  function automatic logic [31:0] mkWord(logic [4:0] f5, logic aq, logic rl, logic [4:0] rs2,
                                         logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f5, aq, rl, rs2, rs1, f3, rd, op};
  endfunction

  task automatic check(string req, string what, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic apply(logic [31:0] w);
    @(negedge clk);
    instrWord = w;
    #1;
  endtask

  // full reference comparison for one base width
  task automatic checkModel(int base, logic [31:0] w);
    logic expHit, expPair, expIll;
    int expSize;
    logic [2:0] f3;
    f3 = w[14:12];
    expHit = (w[6:0] == 7'b0101111) && (w[31:27] == 5'b00101) &&
             (f3 == 3'b010 || f3 == 3'b011 || f3 == 3'b100);
    expSize = !expHit ? 0 : (f3 == 3'b010) ? 0 : (f3 == 3'b011) ? 1 : 2;
    expPair = expHit && ((base == 32 && f3 == 3'b011) || (base == 64 && f3 == 3'b100));
    expIll = expHit && ((base == 32 && f3 == 3'b100) || (expPair && (w[7] || w[20])));
    if (base == 64) begin
      check("R2/R3", "hit64", hit64, expHit);
      check("R3", "size64", size64, expSize);
      check("R5", "pair64", pair64, expPair);
      check((f3 == 3'b100) ? "R6" : "R7", "illegal64", ill64, expIll);
      check("R8", "aq64", aq64, w[26]);
      check("R8", "rl64", rl64, w[25]);
      check("R9", "illWithoutHit64", ill64 && !hit64, 0);
    end else begin
      check("R2/R3", "hit32", hit32, expHit);
      check("R3", "size32", size32, expSize);
      check("R5", "pair32", pair32, expPair);
      check((f3 == 3'b100) ? "R4" : (f3 == 3'b011) ? "R6" : "R7", "illegal32", ill32, expIll);
      check("R8", "aq32", aq32, w[26]);
      check("R8", "rl32", rl32, w[25]);
      check("R9", "illWithoutHit32", ill32 && !hit32, 0);
    end
  endtask

  task automatic t_idle;
    apply(32'h0);
    check("R2", "idle hit64", hit64, 0);
    check("R2", "idle hit32", hit32, 0);
    check("R9", "idle ill64", ill64, 0);
    check("R3", "idle size64", size64, 0);
  endtask

  task automatic t_fields;
    apply(mkWord(5'b00101, 1'b1, 1'b0, 5'd22, 5'd13, 3'b010, 5'd9, 7'b0101111));
    check("R1", "addr64", a64, 13);
    check("R1", "dst64", d64, 9);
    check("R1", "swap64", s64, 22);
    check("R1", "addr32", a32, 13);
    check("R8", "aq", aq64, 1);
    check("R8", "rl", rl64, 0);
    apply(mkWord(5'b00101, 1'b0, 1'b1, 5'd31, 5'd1, 3'b011, 5'd30, 7'b0010011));
    check("R1", "dst on foreign word", d32, 30);
    check("R1", "swap on foreign word", s32, 31);
    check("R8", "rl foreign", rl32, 1);
  endtask

  task automatic t_mismatch;
    apply(mkWord(5'b00101, 1'b0, 1'b0, 5'd3, 5'd2, 3'b100, 5'd1, 7'b0101011));
    check("R2", "bad opcode hit64", hit64, 0);
    check("R2", "bad opcode ill32", ill32, 0);
    apply(mkWord(5'b00001, 1'b0, 1'b0, 5'd3, 5'd2, 3'b011, 5'd1, 7'b0101111));
    check("R2", "swap-select hit64", hit64, 0);
    check("R2", "swap-select ill32", ill32, 0);
    apply(mkWord(5'b10101, 1'b0, 1'b0, 5'd4, 5'd2, 3'b010, 5'd6, 7'b0101111));
    check("R2", "near select hit32", hit32, 0);
  endtask

  task automatic t_sweep;
    for (int f3 = 0; f3 < 8; f3++) begin
      for (int par = 0; par < 4; par++) begin
        for (int ord = 0; ord < 4; ord++) begin
          logic [31:0] w;
          w = mkWord(5'b00101, ord[1], ord[0], {4'd5, par[1]}, 5'd7, f3[2:0], {4'd2, par[0]}, 7'b0101111);
          apply(w);
          checkModel(64, w);
          checkModel(32, w);
        end
      end
    end
  endtask

  task automatic t_corners;
    // odd address index never matters in pair mode
    apply(mkWord(5'b00101, 1'b0, 1'b0, 5'd4, 5'd11, 3'b100, 5'd6, 7'b0101111));
    check("R6", "odd rs1 quad64 legal", ill64, 0);
    check("R5", "quad64 pair", pair64, 1);
    check("R4", "quad32 illegal", ill32, 1);
    check("R4", "quad32 hit", hit32, 1);
    check("R4", "quad32 no pair", pair32, 0);
    // x0 pair is even, hence legal
    apply(mkWord(5'b00101, 1'b1, 1'b1, 5'd0, 5'd1, 3'b011, 5'd0, 7'b0101111));
    check("R6", "x0 pair double32", ill32, 0);
    check("R5", "double32 pair", pair32, 1);
    check("R7", "double64 single", pair64, 0);
    // odd everything on single-register forms
    apply(mkWord(5'b00101, 1'b0, 1'b0, 5'd31, 5'd31, 3'b011, 5'd31, 7'b0101111));
    check("R7", "odd double64", ill64, 0);
    check("R6", "odd double32", ill32, 1);
  endtask

  initial begin
    instrWord = '0;
    repeat (2) @(posedge clk);
    t_idle();
    t_fields();
    t_mismatch();
    t_sweep();
    t_corners();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule